// File: doc/BRIEF.md
# Iterative Decoder Schedule and Output Sequencer

This block sets the timing of the decode and output phases of an iterative sliding-window soft decoder. It holds no decoding arithmetic. When a start event is accepted, the block takes the block size and the iteration count for that block. From these two values and the window-size parameter it derives two cycle counts. The first is the cycle in which the decoded burst must begin. The second is the cycle in which the input side may be given back to the upstream loader.

After start, the block counts valid cycles. On the release count it sends the upstream input controller a one-cycle pulse, so the next block can start loading while the current block's output is still pending or streaming. On the output count it reads decoded hard bits from an external bit store by ascending index and drives them out one per valid cycle with a qualifying ready flag. Because one block can still be waiting for its output slot when the next block starts, pending output deadlines are kept in a short queue. A clock enable freezes the whole block, and a synchronous clear returns it to idle.

Top module: `ds_sequencer`

## Requirements
- R1: Let W be the window size. With block size N and iteration count I, the first cycle with `rdy_o` high comes right after the L-th valid edge counted from the accepted start edge, where L = (W+3) + 2*I*(2*W+19+N).
- R2: `release_o` is high for exactly one valid cycle, right after the S-th valid edge counted from the start edge, where S = L + N - 109 - 3*(W-32). A start is accepted again from the next valid edge onward.
- R3: A `start_i` between an accepted start edge and its release edge is ignored. It causes no extra burst and no extra release, and the timing of the block in flight is unchanged.
- R4: `rdy_o` is high for exactly N valid cycles per block. In the k-th such cycle (k from 0) `dout_o` equals the store bit at index k. `rd_idx_o` presents k during the valid cycle before bit k appears. `dout_o` is 0 whenever `rdy_o` is low.
- R5: A block started on its predecessor's release may begin loading while the predecessor is still waiting for its output slot or is streaming. Up to DEPTH output deadlines are held, and the bursts come out in start order, each on its own R1 time.
- R6: The parameter WIN takes only the values 32 or 64, and L and S follow it as given in R1 and R2.
- R7: While `en_i` is low, no counter moves and `rdy_o`, `dout_o`, `rd_idx_o` and `release_o` keep their values. All cycle counts above count valid edges only.
- R8: `clr_i` high on a valid edge zeroes all counters and drops every pending deadline. `rdy_o`, `dout_o`, `release_o` and `rd_idx_o` are 0 after that edge, and the next start is accepted at once.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; an edge is valid only when high |
| clr_i | input | 1 | Synchronous clear, qualified by `en_i` |
| start_i | input | 1 | Start event for a new block |
| blk_size_i | input | BLK_W | Block size N, sampled at the accepted start |
| iter_i | input | ITER_W | Iteration count I (1 to 15), sampled at the accepted start |
| bit_i | input | 1 | Decoded bit from the store at index `rd_idx_o` |
| dout_o | output | 1 | Decoded hard bit, qualified by `rdy_o` |
| rdy_o | output | 1 | Output-valid flag |
| rd_idx_o | output | BLK_W | Read index into the decoded bit store |
| release_o | output | 1 | One-cycle pulse that re-arms the input loader |

## Verification
A wrong elapsed-cycle counter or a wrong deadline shows up as the first `rdy_o` cycle landing away from the start edge plus L. The same kind of fault also moves the `release_o` pulse from start plus S. Either error appears in the first block and can be measured exactly against the formula. A fault in the index walk or the store fetch shows up in the very first burst as a `dout_o` bit that does not match the store, or as a burst of the wrong length. A faulty deadline queue only shows when blocks are chained back to back at their release points: a burst then goes missing, comes out twice, or carries the wrong length. Enable and clear faults show up at once, as outputs that move while the enable is low, or as stale bursts appearing after a clear.

// File: rtl/ds_pkg.sv
`timescale 1ns/1ps
package ds_pkg;
  localparam int DEF_BLK_W  = 14;
  localparam int DEF_ITER_W = 4;
  localparam int DEF_DEPTH  = 4;

  // cycles the release leads the end of output
  function automatic int rel_trim(input int win);
    return 109 + 3 * (win - 32);
  endfunction
endpackage

// File: rtl/ds_calc.sv
`timescale 1ns/1ps
module ds_calc #(
  parameter int WIN    = 32,
  parameter int BLK_W  = ds_pkg::DEF_BLK_W,
  parameter int ITER_W = ds_pkg::DEF_ITER_W,
  parameter int CNT_W  = BLK_W + ITER_W + 3
) (
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [ITER_W-1:0] iter_i,
  output logic [CNT_W-1:0]  lat_o,
  output logic [CNT_W-1:0]  spc_o
);
  localparam logic [CNT_W-1:0] HEAD   = CNT_W'(WIN + 3);
  localparam logic [CNT_W-1:0] PASS_K = CNT_W'(2 * WIN + 19);
  localparam logic [CNT_W-1:0] TRIM   = CNT_W'(ds_pkg::rel_trim(WIN));

  logic [CNT_W-1:0] pass_len, passes, body;

  always_comb begin
    pass_len = PASS_K + CNT_W'(blk_i);
    passes   = CNT_W'({iter_i, 1'b0});
    body     = passes * pass_len;
    lat_o    = HEAD + body;
    spc_o    = lat_o + CNT_W'(blk_i) - TRIM;
  end
endmodule

// File: rtl/ds_due_q.sv
`timescale 1ns/1ps
module ds_due_q #(
  parameter int DEPTH = ds_pkg::DEF_DEPTH,
  parameter int CNT_W = 21,
  parameter int BLK_W = ds_pkg::DEF_BLK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [CNT_W-1:0] due_i,
  input  logic [BLK_W-1:0] len_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] head_due_o,
  output logic [BLK_W-1:0] head_len_o,
  output logic             valid_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = PTR_W + 1;

  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [FILL_W-1:0] fill_q;
  logic              do_push, do_pop;
  logic [CNT_W-1:0]  due_arr [DEPTH];
  logic [BLK_W-1:0]  len_arr [DEPTH];

  assign do_push = en_i && !clr_i && push_i;
  assign do_pop  = en_i && !clr_i && pop_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CNT_W-1:0] due_q;
    logic [BLK_W-1:0] len_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        due_q <= '0;
        len_q <= '0;
      end else if (do_push && wr_ptr_q == PTR_W'(g)) begin
        due_q <= due_i;
        len_q <= len_i;
      end
    end
    assign due_arr[g] = due_q;
    assign len_arr[g] = len_q;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else if (en_i) begin
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        fill_q   <= '0;
      end else begin
        if (do_push) wr_ptr_q <= bump(wr_ptr_q);
        if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
        case ({do_push, do_pop})
          2'b10:   fill_q <= fill_q + 1'b1;
          2'b01:   fill_q <= fill_q - 1'b1;
          default: fill_q <= fill_q;
        endcase
      end
    end
  end

  assign head_due_o = due_arr[rd_ptr_q];
  assign head_len_o = len_arr[rd_ptr_q];
  assign valid_o    = (fill_q != '0);
  assign full_o     = (fill_q == FILL_W'(DEPTH));

  AST_Q_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_push |-> (!full_o || do_pop)); // R5
  AST_Q_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pop |-> valid_o); // R5
endmodule

// File: rtl/ds_stream.sv
`timescale 1ns/1ps
module ds_stream #(
  parameter int BLK_W = ds_pkg::DEF_BLK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             go_i,
  input  logic [BLK_W-1:0] len_i,
  input  logic             bit_i,
  output logic             rdy_o,
  output logic             dout_o,
  output logic [BLK_W-1:0] idx_o
);
  logic             rdy_q, dout_q;
  logic [BLK_W-1:0] idx_q, left_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      dout_q <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      len_q  <= '0;
    end else if (en_i) begin
      if (clr_i) begin
        rdy_q  <= 1'b0;
        dout_q <= 1'b0;
        idx_q  <= '0;
        left_q <= '0;
        len_q  <= '0;
      end else if (go_i) begin
        rdy_q  <= 1'b1;
        dout_q <= bit_i;
        len_q  <= len_i;
        left_q <= len_i - 1'b1;
        idx_q  <= (len_i == BLK_W'(1)) ? '0 : BLK_W'(1);
      end else if (rdy_q) begin
        if (left_q == '0) begin
          rdy_q  <= 1'b0;
          dout_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          dout_q <= bit_i;
          left_q <= left_q - 1'b1;
          idx_q  <= (left_q == BLK_W'(1)) ? '0 : idx_q + 1'b1;
        end
      end
    end
  end

  assign rdy_o  = rdy_q;
  assign dout_o = dout_q;
  assign idx_o  = idx_q;

  AST_DOUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> !dout_o); // R4
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (idx_o < len_q)); // R4
  AST_GO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && go_i && !clr_i) |-> !rdy_o); // R5
  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(rdy_o) && $stable(dout_o) && $stable(idx_o))); // R7
  AST_CLR_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (!rdy_o && !dout_o && idx_o == '0)); // R8
endmodule

// File: rtl/ds_sequencer.sv
`timescale 1ns/1ps
module ds_sequencer #(
  parameter int WIN    = 32,
  parameter int BLK_W  = ds_pkg::DEF_BLK_W,
  parameter int ITER_W = ds_pkg::DEF_ITER_W,
  parameter int DEPTH  = ds_pkg::DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  blk_size_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic              bit_i,
  output logic              dout_o,
  output logic              rdy_o,
  output logic [BLK_W-1:0]  rd_idx_o,
  output logic              release_o
);
  localparam int CNT_W = BLK_W + ITER_W + 3;

  initial AST_WIN_LEGAL: assert (WIN == 32 || WIN == 64); // R6

  logic [CNT_W-1:0] lat, spc;
  logic [CNT_W-1:0] now_q, rel_left_q;
  logic             busy_q, release_q;
  logic             take;
  logic [CNT_W-1:0] head_due;
  logic [BLK_W-1:0] head_len;
  logic             q_valid, q_full, go;

  ds_calc #(.WIN(WIN), .BLK_W(BLK_W), .ITER_W(ITER_W), .CNT_W(CNT_W)) u_calc (
    .blk_i (blk_size_i),
    .iter_i(iter_i),
    .lat_o (lat),
    .spc_o (spc)
  );

  assign take = en_i && !clr_i && start_i && !busy_q;
  assign go   = q_valid && (head_due == now_q);

  // free-running valid-cycle time base; deadlines compare modulo 2^CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q      <= '0;
      busy_q     <= 1'b0;
      rel_left_q <= '0;
      release_q  <= 1'b0;
    end else if (en_i) begin
      if (clr_i) begin
        now_q      <= '0;
        busy_q     <= 1'b0;
        rel_left_q <= '0;
        release_q  <= 1'b0;
      end else begin
        now_q     <= now_q + 1'b1;
        release_q <= 1'b0;
        if (take) begin
          busy_q     <= 1'b1;
          rel_left_q <= spc - 1'b1;
        end else if (busy_q) begin
          if (rel_left_q == '0) begin
            busy_q    <= 1'b0;
            release_q <= 1'b1;
          end else begin
            rel_left_q <= rel_left_q - 1'b1;
          end
        end
      end
    end
  end

  ds_due_q #(.DEPTH(DEPTH), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_due_q (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .clr_i     (clr_i),
    .push_i    (take),
    .due_i     (now_q + lat),
    .len_i     (blk_size_i),
    .pop_i     (go),
    .head_due_o(head_due),
    .head_len_o(head_len),
    .valid_o   (q_valid),
    .full_o    (q_full)
  );

  ds_stream #(.BLK_W(BLK_W)) u_stream (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .clr_i (clr_i),
    .go_i  (go),
    .len_i (head_len),
    .bit_i (bit_i),
    .rdy_o (rdy_o),
    .dout_o(dout_o),
    .idx_o (rd_idx_o)
  );

  assign release_o = release_q;

  AST_REL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && release_o) |=> !release_o); // R2
  AST_REL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> !busy_q); // R2
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && start_i && busy_q && rel_left_q != '0) |=> busy_q); // R3
  AST_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> !q_full); // R5
  AST_HOLD_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(release_o)); // R7
  AST_CLR_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (!release_o && !busy_q)); // R8
endmodule

// File: tb/ds_sequencer_bench.sv
`timescale 1ns/1ps
module ds_sequencer_bench;
  localparam int BLK_W  = 14;
  localparam int ITER_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0, en = 1'b1, clr = 1'b0, start = 1'b0;
  logic [BLK_W-1:0]  blk = '0;
  logic [ITER_W-1:0] iters = '0;
  logic              bit_a, dout_a, rdy_a, rel_a;
  logic [BLK_W-1:0]  idx_a;
  logic              bit_b, dout_b, rdy_b, rel_b;
  logic [BLK_W-1:0]  idx_b;

  function automatic logic pat(input int k);
    return 1'(((k * 13) >> 2) ^ k);
  endfunction

  assign bit_a = pat(int'(idx_a));
  assign bit_b = pat(int'(idx_b));

  ds_sequencer #(.WIN(32)) u_ds_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .start_i(start),
    .blk_size_i(blk), .iter_i(iters), .bit_i(bit_a),
    .dout_o(dout_a), .rdy_o(rdy_a), .rd_idx_o(idx_a), .release_o(rel_a));

  ds_sequencer #(.WIN(64)) u_ds_sequencer_w64 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .start_i(start),
    .blk_size_i(blk), .iter_i(iters), .bit_i(bit_b),
    .dout_o(dout_b), .rdy_o(rdy_b), .rd_idx_o(idx_b), .release_o(rel_b));

  int n_chk = 0, n_fail = 0;
  int vcnt = 0;
  logic en_d = 1'b0;

  always @(posedge clk) begin
    en_d <= en;
    if (rst_n && en) vcnt <= vcnt + 1;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // burst and release records
  int bn, rn, bidx;
  int bfirst [16];
  int blen [16];
  int rat [16];
  int w_first, w_rel;
  logic mon_on = 1'b0;
  logic p_rdy = 1'b0, wp_rdy = 1'b0;
  logic l_rdy, l_dout, l_rel;
  logic [BLK_W-1:0] l_idx;

  task automatic clear_rec();
    bn = 0; rn = 0; bidx = 0; w_first = 0; w_rel = 0;
    for (int i = 0; i < 16; i++) begin bfirst[i] = 0; blen[i] = 0; rat[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (en_d) begin
        if (rdy_a && !p_rdy && bn < 15) begin bn++; bfirst[bn] = vcnt; bidx = 0; end
        if (rdy_a) begin
          chk(dout_a == pat(bidx), "R4 dout bit", longint'(dout_a), longint'(pat(bidx)));
          bidx++;
          blen[bn] = bidx;
        end
        if (rel_a && rn < 15) begin rn++; rat[rn] = vcnt; end
        if (rdy_b && !wp_rdy && w_first == 0) w_first = vcnt;
        if (rel_b && w_rel == 0) w_rel = vcnt;
        p_rdy = rdy_a;
        wp_rdy = rdy_b;
      end else begin
        chk(rdy_a == l_rdy && dout_a == l_dout && rel_a == l_rel && idx_a == l_idx,
            "R7 hold", longint'({rdy_a, dout_a, rel_a}), longint'({l_rdy, l_dout, l_rel}));
      end
      l_rdy = rdy_a; l_dout = dout_a; l_rel = rel_a; l_idx = idx_a;
    end
  end

  task automatic do_start(input int n, input int it, output int s0);
    blk = BLK_W'(n); iters = ITER_W'(it); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s0 = vcnt;
  endtask

  task automatic wait_to(input int t);
    while (vcnt < t) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(!rdy_a && !dout_a && !rel_a && idx_a == '0, "R9 reset outputs",
        longint'({rdy_a, dout_a, rel_a}), 0);
  endtask

  task automatic test_single();
    int s0, sx;
    clear_rec();
    do_start(10, 1, s0);
    wait_to(s0 + 50);
    do_start(30, 2, sx); // busy: ignored
    wait_to(s0 + 400);
    chk(bn == 1, "R3 one burst", bn, 1);
    chk(bfirst[1] == s0 + 221, "R1 latency W32", bfirst[1] - s0, 221);
    chk(blen[1] == 10, "R4 burst length", blen[1], 10);
    chk(rn == 1, "R3 one release", rn, 1);
    chk(rat[1] == s0 + 122, "R2 release time", rat[1] - s0, 122);
    chk(w_first == s0 + 381, "R6 latency W64", w_first - s0, 381);
    chk(w_rel == s0 + 186, "R6 release W64", w_rel - s0, 186);
  endtask

  task automatic test_overlap();
    int s0, s1;
    clear_rec();
    do_start(150, 2, s0);
    while (rn < 1) @(negedge clk);
    chk(rat[1] == s0 + 1008, "R2 release A", rat[1] - s0, 1008);
    do_start(20, 1, s1);
    wait_to(s1 + 300);
    chk(bn == 2, "R5 two bursts", bn, 2);
    chk(bfirst[1] == s0 + 967, "R1 latency A", bfirst[1] - s0, 967);
    chk(blen[1] == 150, "R4 length A", blen[1], 150);
    chk(bfirst[2] == s1 + 241, "R5 latency B", bfirst[2] - s1, 241);
    chk(blen[2] == 20, "R5 length B", blen[2], 20);
    chk(rat[2] == s1 + 152, "R2 release B", rat[2] - s1, 152);
  endtask

  task automatic test_deep();
    int s [3];
    clear_rec();
    for (int i = 0; i < 3; i++) begin
      do_start(1, 1, s[i]);
      if (i < 2) while (rn < i + 1) @(negedge clk);
    end
    wait_to(s[2] + 250);
    chk(bn == 3, "R5 three bursts", bn, 3);
    for (int i = 0; i < 3; i++) begin
      chk(bfirst[i+1] == s[i] + 203, "R5 queued latency", bfirst[i+1] - s[i], 203);
      chk(blen[i+1] == 1, "R4 single bit burst", blen[i+1], 1);
    end
  endtask

  task automatic test_iter_max();
    int s0;
    clear_rec();
    do_start(5, 15, s0);
    wait_to(s0 + 2700);
    chk(bfirst[1] == s0 + 2675, "R1 latency 15 iterations", bfirst[1] - s0, 2675);
    chk(rat[1] == s0 + 2571, "R2 release 15 iterations", rat[1] - s0, 2571);
    chk(blen[1] == 5, "R4 length", blen[1], 5);
  endtask

  logic gate_on = 1'b0;
  task automatic test_enable();
    int s0, c;
    clear_rec();
    do_start(8, 1, s0);
    gate_on = 1'b1;
    c = 0;
    while (vcnt < s0 + 240) begin
      @(negedge clk);
      c++;
      en = (c % 3 != 0);
    end
    gate_on = 1'b0;
    en = 1'b1;
    wait_to(s0 + 240);
    chk(bfirst[1] == s0 + 217, "R7 latency with gaps", bfirst[1] - s0, 217);
    chk(blen[1] == 8, "R7 length with gaps", blen[1], 8);
    chk(rat[1] == s0 + 116, "R7 release with gaps", rat[1] - s0, 116);
  endtask

  task automatic test_clear();
    int s0, s1, s2, nb;
    clear_rec();
    do_start(40, 1, s0);
    wait_to(s0 + 290);
    chk(rdy_a, "R8 burst running before clear", longint'(rdy_a), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(!rdy_a && !dout_a && !rel_a && idx_a == '0, "R8 outputs after clear",
        longint'({rdy_a, dout_a, rel_a}), 0);
    repeat (5) @(negedge clk);
    clear_rec();
    do_start(10, 1, s1);
    wait_to(s1 + 50);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    do_start(10, 1, s2);
    wait_to(s2 + 300);
    nb = bn;
    chk(nb == 1, "R8 stale deadline dropped", nb, 1);
    chk(bfirst[1] == s2 + 221, "R8 restart latency", bfirst[1] - s2, 221);
    chk(rn == 1 && rat[1] == s2 + 122, "R8 restart release", rat[1] - s2, 122);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog R1: actual %0d expected %0d", vcnt, 0);
    finish_run();
  end

  initial begin
    clear_rec();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    test_single();
    test_overlap();
    test_deep();
    test_iter_max();
    test_enable();
    test_clear();
    finish_run();
  end
endmodule